// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Bit Detection

The block receives asynchronous serial characters on a single line. A sample enable pulse, supplied at sixteen times the baud rate, paces all timing. The line passes through a two-flop synchronizer. While the receiver is hunting, a high-to-low change between two consecutive sample ticks starts a character. The centre of the start bit is placed eight ticks after that change, and each later bit is taken every sixteen ticks. A mode input selects seven or eight data bits, which arrive least significant bit first.

After the last data bit, the polarity of the next sample decides how the character ends. A high level is the stop bit and completes the character. A low level is an address bit, and the sample one cell later must then be the stop bit. A completed character moves into a holding register and raises the data-available bit of the status byte. An interrupt request follows it when enabled. A read strobe releases the holding register. The hunt for the next start edge resumes at the stop-bit sample point, so a following start bit is accepted even if it arrives before the stop cell has ended.

The controller has five states. `S_HUNT` waits for a start edge. `S_START` waits for the centre of the start bit. `S_DATA` shifts in the data bits. `S_POST` judges the sample after the data as an address bit or a stop bit. `S_ASTOP` judges the sample after an address bit. The transitions are:
- edge-found (HUNT→START)
- start-centre (START→DATA)
- last-bit (DATA→POST)
- stop-accept (POST→HUNT)
- addr-seen (POST→ASTOP)
- addr-stop-accept (ASTOP→HUNT)
- frame-drop (ASTOP→HUNT)

Top module: `uart_addr_rx`

## Requirements
- R1: In `S_HUNT`, a character starts only when the synchronized line goes from high to low between two consecutive sample ticks. A line that stays low produces no new character.
- R2: The start bit centre is 8 sample ticks after the detected edge. Every later bit is sampled 16 ticks after the previous one, and data bits are taken least significant bit first.
- R3: When `eight_bit` is 1 the character has 8 data bits. When it is 0 the character has 7 data bits, held in `rx_data[6:0]` with `rx_data[7]` = 0.
- R4: A low sample right after the data bits is an address bit. The character accepted after it shows `rx_status[6]` = 1. A character whose post-data sample is high shows `rx_status[6]` = 0.
- R5: A high sample in the post-data position, or in the post-address position, is the stop bit, and the character is accepted.
- R6: On acceptance, `rx_data` takes the character and `rx_status[7]` is 1 from the next clock. `rx_irq` equals `rx_status[7]` AND `irq_en`.
- R7: A one-clock `rd_strobe` clears `rx_status[7]` (bit 7), `rx_status[5]` (bit 5) and `rx_status[4]` (bit 4) on the next clock, and with them `rx_irq`.
- R8: The hunt for the next start edge resumes at the stop-bit sample point. A start bit that begins 12 ticks into the stop cell is received correctly.
- R9: A low sample after an address bit discards the character. `rx_data` and `rx_status[7]` keep their values, and `rx_status[4]` (framing error) becomes 1.
- R10: A character accepted while `rx_status[7]` is still 1 and no read is in progress overwrites `rx_data` and sets `rx_status[5]` (overrun).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Sample tick at 16x the baud rate |
| rx_in | input | 1 | Serial line, idle high |
| eight_bit | input | 1 | 1: 8 data bits, 0: 7 data bits |
| irq_en | input | 1 | Enables the receive interrupt request |
| rd_strobe | input | 1 | One-clock read of the holding register |
| rx_data | output | 8 | Holding register |
| rx_status | output | 8 | [7] data available, [6] address received, [5] overrun, [4] framing error, [3:0] zero |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A wrong bit counter or sample phase shows up at the ports as a shifted or corrupted byte in `rx_data`. It also moves the address decision to the wrong cell, which flips `rx_status[6]` or raises a false framing error. All of this is visible one clock after the stop sample of that same character. A controller that re-arms late, at the end of the stop cell, misses the next start edge of a back-to-back stream with short stop bits. That fault appears as a missing or garbled following character. Faults in the status holding logic appear within one clock of the acceptance or read that should have changed bits 7, 5 or 4.

// File: rtl/uart_arx_pkg.sv
package uart_arx_pkg;
    typedef enum logic [2:0] {
        S_HUNT  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_POST  = 3'd3,
        S_ASTOP = 3'd4
    } rx_state_e;

    localparam int ST_AVAIL = 7;
    localparam int ST_ADDR  = 6;
    localparam int ST_OVR   = 5;
    localparam int ST_FERR  = 4;
endpackage

// File: rtl/arx_sync_edge.sv
module arx_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= rx_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign rx_s = chain[SYNC_STAGES-1];

    // Level seen at the previous sample tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= rx_s;
    end

    assign fall = tick && prev_q && !rx_s;
endmodule

// File: rtl/arx_bit_timer.sv
module arx_bit_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic half,
    output logic mid
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);

    logic [CW-1:0] cnt_q;

    assign mid = tick && (cnt_q == (half ? HALF_LAST : FULL_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (mid)  cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/arx_shifter.sv
module arx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              short_mode,
    output logic [DATA_W-1:0] char_out
);
    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (clr)      sr_q <= '0;
        else if (shift_en) sr_q <= {bit_in, sr_q[DATA_W-1:1]};
    end

    // Short characters end one position higher; realign them.
    assign char_out = short_mode ? {1'b0, sr_q[DATA_W-1:1]} : sr_q;
endmodule

// File: rtl/arx_holding.sv
module arx_holding
    import uart_arx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] char_in,
    input  logic              addr_in,
    input  logic              frame_err,
    input  logic              rd_strobe,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status,
    output logic              irq
);
    logic avail_q, addr_q, ovr_q, ferr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            avail_q <= 1'b0;
            addr_q  <= 1'b0;
            ovr_q   <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            if (accept) begin
                rx_data <= char_in;
                addr_q  <= addr_in;
                avail_q <= 1'b1;
                ovr_q   <= (avail_q && !rd_strobe) ? 1'b1 : (ovr_q && !rd_strobe);
            end else if (rd_strobe) begin
                avail_q <= 1'b0;
                ovr_q   <= 1'b0;
            end
            if (frame_err)      ferr_q <= 1'b1;
            else if (rd_strobe) ferr_q <= 1'b0;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_AVAIL] = avail_q;
        status[ST_ADDR]  = addr_q;
        status[ST_OVR]   = ovr_q;
        status[ST_FERR]  = ferr_q;
    end

    assign irq = avail_q && irq_en;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_arx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              rx_in,
    input  logic              eight_bit,
    input  logic              irq_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        rx_status,
    output logic              rx_irq
);
    localparam int IW = $clog2(DATA_W);
    localparam logic [IW-1:0] LAST_LONG  = IW'(DATA_W - 1);
    localparam logic [IW-1:0] LAST_SHORT = IW'(DATA_W - 2);

    rx_state_e state_q, state_d;
    logic [IW-1:0] bit_idx_q;
    logic          rx_s, start_fall, mid;
    logic          timer_clr, half, shift_en, sr_clr;
    logic          char_done, frame_bad, addr_set, addr_q;
    logic [DATA_W-1:0] char_w;

    arx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick(samp_en), .rx_in(rx_in),
        .rx_s(rx_s), .fall(start_fall)
    );

    arx_bit_timer #(.OSR(OSR)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(samp_en),
        .half(half), .mid(mid)
    );

    arx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sr_clr), .shift_en(shift_en),
        .bit_in(rx_s), .short_mode(!eight_bit), .char_out(char_w)
    );

    arx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .accept(char_done), .char_in(char_w),
        .addr_in(addr_q), .frame_err(frame_bad), .rd_strobe(rd_strobe),
        .irq_en(irq_en), .rx_data(rx_data), .status(rx_status), .irq(rx_irq)
    );

    // State register and the counters that travel with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_HUNT;
            bit_idx_q <= '0;
            addr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sr_clr)        bit_idx_q <= '0;
            else if (shift_en) bit_idx_q <= bit_idx_q + 1'b1;
            if (sr_clr)        addr_q <= 1'b0;
            else if (addr_set) addr_q <= 1'b1;
        end
    end

    // Next-state decisions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT:  if (start_fall) state_d = S_START;
            S_START: if (mid) state_d = S_DATA;
            S_DATA:  if (mid && bit_idx_q == (eight_bit ? LAST_LONG : LAST_SHORT))
                         state_d = S_POST;
            S_POST:  if (mid) state_d = rx_s ? S_HUNT : S_ASTOP;
            S_ASTOP: if (mid) state_d = S_HUNT;
            default: state_d = S_HUNT;
        endcase
    end

    // Control outputs of the controller.
    always_comb begin
        timer_clr = 1'b0;
        half      = 1'b0;
        shift_en  = 1'b0;
        sr_clr    = 1'b0;
        char_done = 1'b0;
        frame_bad = 1'b0;
        addr_set  = 1'b0;
        unique case (state_q)
            S_HUNT: begin
                timer_clr = 1'b1;
                sr_clr    = start_fall;
            end
            S_START: half = 1'b1;
            S_DATA:  shift_en = mid;
            S_POST: begin
                char_done = mid && rx_s;
                addr_set  = mid && !rx_s;
            end
            S_ASTOP: begin
                char_done = mid && rx_s;
                frame_bad = mid && !rx_s;
            end
            default: timer_clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_arx_chk.sv
module uart_arx_chk
    import uart_arx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      rd_strobe,
    input logic      irq_en,
    input logic      irq,
    input logic [7:0] status,
    input logic      accept,
    input logic      ferr,
    input logic      fall,
    input rx_state_e state
);
    // R1
    hunt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HUNT && !fall) |=> (state == S_HUNT));

    // R6
    accept_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> status[ST_AVAIL]);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !accept) |=> (!status[ST_AVAIL] && !status[ST_OVR]));

    // R9
    frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && !rd_strobe) |=> (status[ST_FERR] && status[ST_AVAIL] == $past(status[ST_AVAIL])));

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && status[ST_AVAIL] && !rd_strobe) |=> status[ST_OVR]);
endmodule

bind uart_addr_rx uart_arx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .irq_en(irq_en),
    .irq(rx_irq), .status(rx_status), .accept(char_done), .ferr(frame_bad),
    .fall(start_fall), .state(state_q)
);

// File: tb/sim_uart_addr_rx.sv
module sim_uart_addr_rx;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, samp_en, rx, eight, irq_en, rd_mon, rd_dir;
    logic [7:0] data, status;
    logic       irq;
    int         n_chk = 0, n_fail = 0;
    bit         auto_rd = 1'b0;

    typedef struct { logic [7:0] d; logic a; } exp_t;
    exp_t exp_q[$];

    uart_addr_rx u0 (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_in(rx),
        .eight_bit(eight), .irq_en(irq_en), .rd_strobe(rd_mon | rd_dir),
        .rx_data(data), .rx_status(status), .rx_irq(irq)
    );

    // Sample tick every second clock.
    always @(negedge clk) begin
        if (!rst_n) samp_en <= 1'b0;
        else        samp_en <= ~samp_en;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    // mode: 0 plain, 1 address bit then stop, 2 address bit then low stop
    task automatic send(input logic [7:0] d, input int mode, input int stop_t, input bit push);
        exp_t e;
        int nb = eight ? 8 : 7;
        e.d = eight ? d : {1'b0, d[6:0]};
        e.a = (mode == 1);
        if (push) exp_q.push_back(e);
        rx = 1'b0; ticks(16);
        for (int i = 0; i < nb; i++) begin
            rx = d[i]; ticks(16);
        end
        if (mode != 0) begin
            rx = 1'b0; ticks(16);
        end
        rx = (mode == 2) ? 1'b0 : 1'b1;
        ticks(stop_t);
    endtask

    task automatic read_dir();
        rd_dir = 1'b1; @(negedge clk); rd_dir = 1'b0; @(negedge clk);
    endtask

    // Scoreboard monitor.
    initial begin
        exp_t e;
        rd_mon = 1'b0;
        forever begin
            @(negedge clk);
            if (auto_rd && status[7]) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected character", data, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(data == e.d, "R2", "data", data, e.d);
                    check(status[6] == e.a, "R4", "address flag", status[6], e.a);
                    check(irq == irq_en, "R6", "irq", irq, irq_en);
                end
                rd_mon = 1'b1; @(negedge clk); rd_mon = 1'b0;
                check(status[7] == 1'b0 && irq == 1'b0, "R7", "avail after read",
                      {status[7], irq}, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx = 1'b1; eight = 1'b1; irq_en = 1'b1; rd_dir = 1'b0;
        repeat (5) @(negedge clk);
        check(status == 8'h00 && data == 8'h00 && irq == 1'b0, "R6", "reset state",
              {status, data}, 0);
        rst_n = 1'b1;
        ticks(20);

        // R2 R3 R5: 8-bit patterns through the scoreboard.
        auto_rd = 1'b1;
        send(8'hA5, 0, 16, 1); ticks(4);
        send(8'h00, 0, 16, 1); ticks(4);
        send(8'hFF, 0, 16, 1); ticks(4);
        send(8'h3C, 0, 16, 1); ticks(4);
        // R4: address bit, 8-bit mode.
        send(8'h81, 1, 16, 1); ticks(4);
        // R3: 7-bit mode, with and without address bit.
        eight = 1'b0;
        send(8'hD5, 0, 16, 1); ticks(4);
        send(8'h7F, 1, 16, 1); ticks(4);
        eight = 1'b1;
        // R8: back-to-back, stop cell cut to 12 ticks.
        send(8'h96, 0, 12, 1);
        send(8'hF0, 1, 12, 1);
        send(8'hFE, 0, 12, 1);
        send(8'h0F, 0, 16, 1);
        ticks(10);
        check(exp_q.size() == 0, "R8", "characters left", exp_q.size(), 0);
        auto_rd = 1'b0;

        // R6: irq gating.
        irq_en = 1'b0;
        send(8'h5A, 0, 16, 0); ticks(4);
        check(status[7] == 1'b1 && irq == 1'b0, "R6", "irq disabled", {status[7], irq}, 2);
        irq_en = 1'b1; @(negedge clk);
        check(irq == 1'b1, "R6", "irq enabled", irq, 1);

        // R10: second character without a read.
        send(8'h22, 0, 16, 0); ticks(4);
        check(status[5] == 1'b1 && data == 8'h22, "R10", "overrun", {status[5], data}, 9'h122);
        read_dir();
        check(status[7:4] == 4'b0000, "R7", "flags after read", status[7:4], 0);

        // R9: low stop after address bit, then line held low (R1).
        send(8'h44, 2, 16, 0);
        ticks(40);
        rx = 1'b1; ticks(20);
        check(status[4] == 1'b1, "R9", "framing flag", status[4], 1);
        check(status[7] == 1'b0 && data == 8'h22, "R9", "data kept", {status[7], data}, 8'h22);
        check(irq == 1'b0, "R1", "no character from held-low line", irq, 0);
        read_dir();
        check(status[4] == 1'b0, "R7", "framing cleared", status[4], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule